// File: doc/BRIEF.md
# Unpacked Decimal Adjust Unit

This block repairs a 16-bit accumulator after a binary add or subtract of two unpacked decimal digits. The accumulator is split into a high lane (bits 15:8) and a low lane (bits 7:0), and a decimal digit lives in the low nibble of the low lane. If that nibble is above nine, or the incoming half-carry flag is set, the block corrects the result. It adds or subtracts 0x0106 across the whole word, so the low lane moves by six and the high lane by one, and any carry or borrow out of the low lane also reaches the high lane. It then clears bits 7:4 and produces a complete set of status flags.

One operation enters per accepted input beat. The result is registered once and leaves on a valid/ready output. Back-pressure works as follows. The block accepts a new input (`in_ready` high) whenever its output register is empty or that register is being drained in the same cycle (`out_valid && out_ready`). While `out_valid` is high and `out_ready` is low, the output register and every output field hold their values, and `in_ready` is low. Instruction decode, register storage and flag write-back are done elsewhere.

Top module: `bcd_adj_unit`

## Requirements
- R1: A correction is made when bits 3:0 of the input accumulator are greater than 9, or when `in_af` is 1. Otherwise no correction is made.
- R2: With `in_sub`=0 and a correction, the word is `in_acc + 0x0106` modulo 2^16, so a carry out of bits 7:0 increments bits 15:8 a second time.
- R3: With `in_sub`=1 and a correction, the word is `in_acc - 0x0106` modulo 2^16, so a borrow out of bits 7:0 decrements bits 15:8 a second time.
- R4: `out_cf` and `out_af` are both 1 when a correction was made and both 0 otherwise. The incoming `in_cf` has no effect on any output.
- R5: `out_acc[7:4]` is always 0. Without a correction, `out_acc[15:8]` equals `in_acc[15:8]` and `out_acc[3:0]` equals `in_acc[3:0]`.
- R6: `out_of` and `out_sf` are always 0.
- R7: `out_zf` is 1 exactly when `out_acc[7:0]` is 0. `out_pf` is 1 exactly when `out_acc[7:0]` has an even number of one bits.
- R8: An input is taken on a rising edge with `in_valid && in_ready`. Its result appears on the outputs after that edge, with `out_valid` high. `in_ready` equals `!out_valid || out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs hold their values at the next edge.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_acc` and all flag outputs at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_acc | input | 16 | Accumulator before adjustment |
| in_af | input | 1 | Incoming half-carry flag |
| in_cf | input | 1 | Incoming carry flag (unused by the function) |
| in_sub | input | 1 | 0: adjust after add, 1: adjust after subtract |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_acc | output | 16 | Adjusted accumulator |
| out_cf | output | 1 | Carry flag |
| out_af | output | 1 | Half-carry flag |
| out_of | output | 1 | Overflow flag |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_pf | output | 1 | Parity flag (even) |

## Verification
Directed words put the low nibble at 9, A and F, and these are tried with the half-carry flag both clear and set. This separates the two triggers of R1 and shows an off-by-one in the nibble comparison. Words with a low lane near 0xFA in add mode, and near 0x00 in subtract mode, show whether the lane carry or borrow reaches the high lane. Words 0xFFFF and 0x0000 also wrap the whole accumulator. Random words, random `in_cf` values and random consumer stalls then test the flag rules, the independence from `in_cf`, and whether the output holds during back-pressure.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  parameter int ACC_W  = 16;
  parameter int LANE_W = ACC_W / 2;
  parameter int NIB_W  = 4;
  parameter int DIGIT_MAX = 9;
  parameter int LOW_STEP  = 6;

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic             cf;
    logic             af;
    logic             ovf;
    logic             sgn;
    logic             zf;
    logic             pf;
  } adj_result_t;

endpackage

// File: rtl/bcd_adj_detect.sv
module bcd_adj_detect #(
  parameter int NIB_W = 4,
  parameter int LIMIT = 9
) (
  input  logic [NIB_W-1:0] digit,
  input  logic             half_carry,
  output logic             need
);
  localparam logic [NIB_W-1:0] LIM = NIB_W'(LIMIT);

  always_comb begin
    need = half_carry || (digit > LIM);
  end
endmodule

// File: rtl/bcd_adj_word.sv
module bcd_adj_word #(
  parameter int ACC_W  = 16,
  parameter int LANE_W = 8,
  parameter int NIB_W  = 4,
  parameter int STEP   = 6
) (
  input  logic [ACC_W-1:0]  acc_in,
  input  logic              need,
  input  logic              sub,
  output logic [ACC_W-1:0]  acc_out
);
  localparam logic [ACC_W-1:0] CORR = ACC_W'((1 << LANE_W) + STEP);

  logic [ACC_W-1:0] sum_w;
  logic [ACC_W-1:0] dif_w;
  logic [ACC_W-1:0] pick_w;

  always_comb begin
    sum_w = acc_in + CORR;
    dif_w = acc_in - CORR;
    if (!need)     pick_w = acc_in;
    else if (sub)  pick_w = dif_w;
    else           pick_w = sum_w;
  end

  // keep the digit nibble and the high lane, wipe the zone bits between
  genvar gi;
  generate
    for (gi = 0; gi < ACC_W; gi++) begin : g_mask
      if (gi >= NIB_W && gi < LANE_W) begin : g_zone
        assign acc_out[gi] = 1'b0;
      end else begin : g_keep
        assign acc_out[gi] = pick_w[gi];
      end
    end
  endgenerate

  always_comb begin
    if (!need) begin
      assert (acc_out[ACC_W-1:LANE_W] == acc_in[ACC_W-1:LANE_W])
        else $error("p_high_lane_kept_r5");
    end
  end
endmodule

// File: rtl/bcd_adj_flags.sv
module bcd_adj_flags #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane,
  input  logic              need,
  output logic              cf,
  output logic              af,
  output logic              ovf,
  output logic              sgn,
  output logic              zf,
  output logic              pf
);
  always_comb begin
    cf  = need;
    af  = need;
    ovf = 1'b0;
    sgn = lane[LANE_W-1];
    zf  = (lane == '0);
    pf  = ~^lane;
  end
endmodule

// File: rtl/bcd_adj_stage.sv
module bcd_adj_stage
  import bcd_adj_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  adj_result_t in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output adj_result_t out_data
);
  logic        v_q;
  adj_result_t d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end

  p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (v_q && !out_ready) |=> (v_q && $stable(d_q)));

  p_take_shows_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> v_q);

  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!v_q && d_q == '0));
endmodule

// File: rtl/bcd_adj_unit.sv
module bcd_adj_unit
  import bcd_adj_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ACC_W-1:0]  in_acc,
  input  logic              in_af,
  input  logic              in_cf,
  input  logic              in_sub,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_acc,
  output logic              out_cf,
  output logic              out_af,
  output logic              out_of,
  output logic              out_sf,
  output logic              out_zf,
  output logic              out_pf
);
  logic             need;
  logic [ACC_W-1:0] fixed_acc;
  adj_result_t      res_d;
  adj_result_t      res_q;
  logic             unused_cf;

  assign unused_cf = in_cf;

  bcd_adj_detect #(.NIB_W(NIB_W), .LIMIT(DIGIT_MAX)) u_detect (
    .digit      (in_acc[NIB_W-1:0]),
    .half_carry (in_af),
    .need       (need)
  );

  bcd_adj_word #(.ACC_W(ACC_W), .LANE_W(LANE_W), .NIB_W(NIB_W), .STEP(LOW_STEP)) u_word (
    .acc_in  (in_acc),
    .need    (need),
    .sub     (in_sub),
    .acc_out (fixed_acc)
  );

  assign res_d.acc = fixed_acc;

  bcd_adj_flags #(.LANE_W(LANE_W)) u_flags (
    .lane (fixed_acc[LANE_W-1:0]),
    .need (need),
    .cf   (res_d.cf),
    .af   (res_d.af),
    .ovf  (res_d.ovf),
    .sgn  (res_d.sgn),
    .zf   (res_d.zf),
    .pf   (res_d.pf)
  );

  bcd_adj_stage u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q)
  );

  assign out_acc = res_q.acc;
  assign out_cf  = res_q.cf;
  assign out_af  = res_q.af;
  assign out_of  = res_q.ovf;
  assign out_sf  = res_q.sgn;
  assign out_zf  = res_q.zf;
  assign out_pf  = res_q.pf;

  p_zone_clear_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_acc[LANE_W-1:NIB_W] == '0));

  p_fixed_flags_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!out_of && !out_sf));

  p_flag_pair_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cf == out_af));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_zf == (out_acc[LANE_W-1:0] == '0)));

  p_trigger_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_af || in_acc[NIB_W-1:0] > 4'd9)) |=> out_cf);
endmodule

// File: tb/bcd_adj_unit_bench.sv
module bcd_adj_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_acc = '0;
  logic        in_af = 1'b0;
  logic        in_cf = 1'b0;
  logic        in_sub = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_acc;
  logic        out_cf, out_af, out_of, out_sf, out_zf, out_pf;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference state
  bit mv = 0;
  bit mchk = 0;
  int m_acc = 0, m_cf = 0, m_af = 0, m_zf = 0, m_pf = 0;

  always #4 clk = ~clk;

  bcd_adj_unit u_bcd_adj_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_af(in_af), .in_cf(in_cf), .in_sub(in_sub),
    .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc),
    .out_cf(out_cf), .out_af(out_af), .out_of(out_of), .out_sf(out_sf),
    .out_zf(out_zf), .out_pf(out_pf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // compute expected result from the requirement text
  task automatic model(input int acc, input bit af, input bit sub);
    int a, lo, ones;
    bit need;
    need = ((acc & 15) > 9) || af;              // R1
    a = acc;
    if (need && !sub) a = (a + 'h106) & 'hFFFF; // R2
    if (need && sub)  a = (a - 'h106) & 'hFFFF; // R3
    a = a & 'hFF0F;                             // R5
    lo = a & 'hFF;
    ones = 0;
    for (int b = 0; b < 8; b++) ones += (lo >> b) & 1;
    m_acc = a;
    m_cf = need; m_af = need;                   // R4
    m_zf = (lo == 0);                           // R7
    m_pf = (ones % 2 == 0);
  endtask

  // compare outputs against the model after the last edge
  task automatic compare_now();
    chk("R8 out_valid", out_valid, mv);
    if (mv || mchk) begin
      chk("R2/R3/R5 out_acc", out_acc, m_acc);
      chk("R4 out_cf", out_cf, m_cf);
      chk("R4 out_af", out_af, m_af);
      chk("R6 out_of", out_of, 0);
      chk("R6 out_sf", out_sf, 0);
      chk("R7 out_zf", out_zf, m_zf);
      chk("R7 out_pf", out_pf, m_pf);
    end
  endtask

  // one cycle: drive at negedge, update model for the coming edge
  task automatic step(input bit v, input int acc, input bit af, input bit cf,
                      input bit sub, input bit rdy, input bit r);
    @(negedge clk);
    compare_now();
    in_valid = v; in_acc = acc[15:0]; in_af = af; in_cf = cf; in_sub = sub;
    out_ready = rdy; rst = r;
    #1;
    if (!r) chk("R8 in_ready", in_ready, (!mv || rdy));
    if (r) begin
      mv = 0; mchk = 1;                         // R10
      m_acc = 0; m_cf = 0; m_af = 0; m_zf = 0; m_pf = 0;
    end else begin
      bit take;
      take = v && (!mv || rdy);
      if (mv && rdy) begin mv = 0; mchk = 0; end
      if (take) begin model(acc, af, sub); mv = 1; end
      // R9: on stall the model keeps its values, so compare_now checks hold
    end
  endtask

  initial begin
    // reset
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1, 0);   // R10 reset state compared here
    // directed: nibble edges, flag trigger, lane carry and borrow
    step(1, 'h0009, 0, 0, 0, 1, 0); // R1 no correction
    step(1, 'h000A, 0, 0, 0, 1, 0); // R1 nibble 10
    step(1, 'h000F, 0, 1, 0, 1, 0);
    step(1, 'h0009, 1, 0, 0, 1, 0); // R1 via half-carry
    step(1, 'h12FA, 0, 0, 0, 1, 0); // R2 lane carry
    step(1, 'hFFFF, 0, 0, 0, 1, 0); // R2 word wrap
    step(1, 'h3400, 1, 0, 1, 1, 0); // R3 lane borrow
    step(1, 'h0005, 1, 1, 1, 1, 0); // R3 word wrap
    step(1, 'h000B, 0, 0, 1, 1, 0); // R3 nibble
    step(1, 'h7793, 0, 1, 1, 1, 0); // R5 no correction, zone cleared
    step(1, 'h5570, 0, 0, 0, 1, 0); // R7 zero low lane
    // R9 stall with a new offer pending
    step(1, 'h0A0C, 0, 0, 0, 0, 0);
    step(1, 'h0101, 0, 0, 1, 0, 0);
    step(1, 'h0101, 0, 0, 1, 0, 0);
    step(1, 'h0101, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    // R4: in_cf must not matter, same word twice
    step(1, 'h2208, 0, 0, 0, 1, 0);
    step(1, 'h2208, 0, 1, 0, 1, 0);
    // random traffic with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 'hFFFF),
           $urandom_range(0, 3) == 0, $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 2) != 0, 0);
    end
    // R10 reset while holding a result
    step(1, 'h00AA, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    compare_now();
    finish_run();
  end
endmodule